// File: doc/BRIEF.md
# Multiplexed Bus Address-Phase Decoder

This block sits beside a 64-bit multiplexed address/data bus whose eight command/byte-enable lines are active low. A start strobe marks the first clock of each transaction and a level input stays high for every clock the transaction occupies. The decoder separates the address clock from the data clocks. In a dual-address cycle the 64-bit address arrives in two 32-bit halves over two clocks, and the real command travels on the upper four lines of the first clock. The decoder reassembles that address and reports it once.

Every output is registered, so each result appears one clock after the bus clock that produced it. The address side gives a one-clock `addr_valid` pulse together with the address, the command and a dual-address flag. These values hold until the next pulse. The data side gives a one-clock `beat_valid` per data clock with the bus word and active-high lane enables. Both are pure valid streams with no ready input: the bus cannot be stalled, so the consumer must accept every pulse in the cycle it appears.

The block also computes even parity over the low 32 bus bits and the low four command/byte-enable lines. It compares that parity with the parity input one clock later and pulses an error on a mismatch.

Top module: `mbus_addr_decoder`

## Requirements
- R1: While `rst_n` is low, `addr_valid`, `beat_valid`, `par_err`, `dac`, `par_gen`, `addr`, `cmd`, `beat_data` and `beat_be` are all zero.
- R2: A clock with `start` high and `cbe_n[3:0]` not equal to 4'b1101 is a single address clock. In the next cycle `addr_valid` pulses for one cycle, `addr` equals that clock's `ad`, `cmd` equals its `cbe_n[3:0]` (the raw line levels) and `dac` is 0. These values hold until the next `addr_valid`.
- R3: A clock with `start` high and `cbe_n[3:0]` equal to 4'b1101 opens a dual-address transaction. No `addr_valid` follows that clock, and the command reported later is that clock's `cbe_n[7:4]`.
- R4: The clock after a dual-address first clock, with `active` high and `start` low, is the second address clock. In the next cycle `addr_valid` pulses, `dac` is 1, `addr[63:32]` is this clock's `ad[31:0]` and `addr[31:0]` is the first clock's `ad[31:0]`. This clock's `cbe_n[3:0]` and `ad[63:32]` have no effect on `cmd` or `addr`.
- R5: For each data beat, `beat_be[i]` is the inverse of `cbe_n[i]`, and lane i is `beat_data[8*i+7:8*i]`. Line 0 is byte 0 (bits 7:0) and line 7 is byte 7 (bits 63:56).
- R6: Every clock with `active` high and `start` low that follows the address clock or clocks gives a `beat_valid` pulse in the next cycle, with `beat_data` equal to that clock's `ad`. A burst may have any number of beats, and address clocks never produce a beat.
- R7: `par_gen` equals the XOR of `ad[31:0]` and `cbe_n[3:0]` from the previous clock.
- R8: When the previous clock had `start` or `active` high, `par` must equal that clock's `par_gen` value. On a mismatch, `par_err` is high for exactly the cycle after the clock that carried `par`. When they match, `par_err` stays low.
- R9: A clock with both `start` and `active` low ends the transaction. Such a clock produces no `addr_valid` or `beat_valid` and leaves `addr`, `cmd` and `dac` unchanged, and the next `start` is decoded as a fresh address clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | High on the first clock of a transaction |
| active | input | 1 | High on every clock of a transaction |
| ad | input | 64 | Multiplexed address/data bus |
| cbe_n | input | 8 | Active-low command/byte-enable lines |
| par | input | 1 | Even parity for the previous clock's low bus half and low four lines |
| addr_valid | output | 1 | One-cycle pulse: a full address has been decoded |
| addr | output | 64 | Decoded byte address |
| cmd | output | 4 | Decoded bus command (raw line levels) |
| dac | output | 1 | The last address came from a dual-address transaction |
| beat_valid | output | 1 | One-cycle pulse per data clock |
| beat_data | output | 64 | Data word of the beat |
| beat_be | output | 8 | Active-high byte-lane enables of the beat |
| par_gen | output | 1 | Parity generated from the previous clock |
| par_err | output | 1 | One-cycle parity mismatch pulse |

## Verification
The properties assume that `start` never stays high for two clocks in a row and that a dual-address opening is followed by a second address clock with `start` low. They also assume that inputs are known from the first clock after reset. The bench drives every input on the falling edge. Each `start` is a single-clock pulse that opens either a single or a dual-address transaction, and the bench holds `start` and `active` low throughout reset. Parity is driven one clock late from a value the bench computes, and it is corrupted only on purpose when the error pulse is under test.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DAC_HI = 2'd1,
    PH_DATA   = 2'd2
  } phase_e;

  localparam logic [3:0] CMD_DUAL_ADDR = 4'b1101;
endpackage

// File: rtl/mbd_phase_tracker.sv
module mbd_phase_tracker
  import mbd_pkg::*;
#(
  parameter int              CMD_W   = 4,
  parameter logic [CMD_W-1:0] DAC_CMD = CMD_DUAL_ADDR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic [CMD_W-1:0] cmd_lo,
  output logic             addr_clk,
  output logic             dac_first,
  output logic             dac_second,
  output logic             data_clk
);
  phase_e phase_q, phase_d;

  always_comb begin
    addr_clk   = start;
    dac_first  = start && (cmd_lo == DAC_CMD);
    dac_second = !start && active && (phase_q == PH_DAC_HI);
    data_clk   = !start && active && (phase_q == PH_DATA);
  end

  always_comb begin
    phase_d = phase_q;
    if (start)
      phase_d = dac_first ? PH_DAC_HI : PH_DATA;
    else if (!active)
      phase_d = PH_IDLE;
    else if (phase_q == PH_DAC_HI)
      phase_d = PH_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/mbd_addr_capture.sv
module mbd_addr_capture #(
  parameter int ADDR_W = 64,
  parameter int CMD_W  = 4,
  localparam int HALF_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_clk,
  input  logic              dac_first,
  input  logic              dac_second,
  input  logic [ADDR_W-1:0] ad,
  input  logic [CMD_W-1:0]  cmd_lo,
  input  logic [CMD_W-1:0]  cmd_hi,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic [CMD_W-1:0]  cmd,
  output logic              dac
);
  logic [HALF_W-1:0] lo_stage_q;
  logic [CMD_W-1:0]  cmd_stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_stage_q  <= '0;
      cmd_stage_q <= '0;
      addr_valid  <= 1'b0;
      addr        <= '0;
      cmd         <= '0;
      dac         <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      if (dac_first) begin
        lo_stage_q  <= ad[HALF_W-1:0];
        cmd_stage_q <= cmd_hi;
      end else if (addr_clk) begin
        addr_valid <= 1'b1;
        addr       <= ad;
        cmd        <= cmd_lo;
        dac        <= 1'b0;
      end else if (dac_second) begin
        addr_valid <= 1'b1;
        addr       <= {ad[HALF_W-1:0], lo_stage_q};
        cmd        <= cmd_stage_q;
        dac        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbd_beat_out.sv
module mbd_beat_out #(
  parameter int DATA_W = 64,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_clk,
  input  logic [DATA_W-1:0] ad,
  input  logic [BE_W-1:0]   cbe_n,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  output logic [BE_W-1:0]   beat_be
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_valid <= 1'b0;
      beat_data  <= '0;
    end else begin
      beat_valid <= data_clk;
      if (data_clk) beat_data <= ad;
    end
  end

  for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        beat_be[lane] <= 1'b0;
      else if (data_clk) beat_be[lane] <= ~cbe_n[lane];
    end
  end
endmodule

// File: rtl/mbd_parity.sv
module mbd_parity #(
  parameter int PAR_W = 32,
  parameter int CMD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic [PAR_W-1:0] ad_lo,
  input  logic [CMD_W-1:0] cbe_lo,
  input  logic             par,
  output logic             par_gen,
  output logic             par_err
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_gen <= 1'b0;
      armed_q <= 1'b0;
      par_err <= 1'b0;
    end else begin
      par_gen <= ^{ad_lo, cbe_lo};
      armed_q <= armed;
      par_err <= armed_q && (par != par_gen);
    end
  end
endmodule

// File: rtl/mbus_addr_decoder.sv
module mbus_addr_decoder
  import mbd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CMD_W  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic [DATA_W-1:0] ad,
  input  logic [BE_W-1:0]   cbe_n,
  input  logic              par,
  output logic              addr_valid,
  output logic [DATA_W-1:0] addr,
  output logic [CMD_W-1:0]  cmd,
  output logic              dac,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  output logic [BE_W-1:0]   beat_be,
  output logic              par_gen,
  output logic              par_err
);
  logic addr_clk, dac_first, dac_second, data_clk;
  logic [CMD_W-1:0] cmd_lo, cmd_hi;

  assign cmd_lo = cbe_n[CMD_W-1:0];
  assign cmd_hi = cbe_n[2*CMD_W-1:CMD_W];

  mbd_phase_tracker #(.CMD_W(CMD_W), .DAC_CMD(CMD_DUAL_ADDR)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(start), .active(active), .cmd_lo(cmd_lo),
    .addr_clk(addr_clk), .dac_first(dac_first), .dac_second(dac_second),
    .data_clk(data_clk)
  );

  mbd_addr_capture #(.ADDR_W(DATA_W), .CMD_W(CMD_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_clk(addr_clk), .dac_first(dac_first),
    .dac_second(dac_second), .ad(ad), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .addr_valid(addr_valid), .addr(addr), .cmd(cmd), .dac(dac)
  );

  mbd_beat_out #(.DATA_W(DATA_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .data_clk(data_clk), .ad(ad), .cbe_n(cbe_n),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_be(beat_be)
  );

  mbd_parity #(.PAR_W(HALF_W), .CMD_W(CMD_W)) u_par (
    .clk(clk), .rst_n(rst_n), .armed(start || active),
    .ad_lo(ad[HALF_W-1:0]), .cbe_lo(cmd_lo), .par(par),
    .par_gen(par_gen), .par_err(par_err)
  );
endmodule

// File: rtl/mbd_checker.sv
module mbd_checker #(
  parameter int DATA_W = 64,
  parameter int CMD_W  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int HALF_W = DATA_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              active,
  input logic [DATA_W-1:0] ad,
  input logic [BE_W-1:0]   cbe_n,
  input logic              addr_valid,
  input logic [DATA_W-1:0] addr,
  input logic              dac,
  input logic              beat_valid,
  input logic [BE_W-1:0]   beat_be,
  input logic              par_err
);
  localparam logic [CMD_W-1:0] DUAL = 4'b1101;

  a_r2_single_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cbe_n[CMD_W-1:0] != DUAL) |=> (addr_valid && !dac && addr == $past(ad)));

  a_r3_dac_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cbe_n[CMD_W-1:0] == DUAL) |=> !addr_valid);

  a_r4_dac_join: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && active && $past(start) && $past(cbe_n[CMD_W-1:0]) == DUAL)
      |=> (addr_valid && dac && addr[HALF_W-1:0] == $past(ad[HALF_W-1:0], 2)));

  a_r5_lane_enables: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_be == ~$past(cbe_n)));

  a_r6_beat_source: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ($past(active) && !$past(start)));

  a_r8_err_armed: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> ($past(start, 2) || $past(active, 2)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !active) |=> (!beat_valid && !addr_valid));
endmodule

bind mbus_addr_decoder mbd_checker #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .active(active), .ad(ad),
  .cbe_n(cbe_n), .addr_valid(addr_valid), .addr(addr), .dac(dac),
  .beat_valid(beat_valid), .beat_be(beat_be), .par_err(par_err)
);

// File: tb/mbus_addr_decoder_test.sv
module mbus_addr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, active = 1'b0, par = 1'b0;
  logic [63:0] ad = '0;
  logic [7:0]  cbe_n = 8'hFF;
  logic        addr_valid, dac, beat_valid, par_gen, par_err;
  logic [63:0] addr, beat_data;
  logic [3:0]  cmd;
  logic [7:0]  beat_be;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_par = 1'b0;

  always #10 clk = ~clk;

  mbus_addr_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .active(active), .ad(ad),
    .cbe_n(cbe_n), .par(par), .addr_valid(addr_valid), .addr(addr),
    .cmd(cmd), .dac(dac), .beat_valid(beat_valid), .beat_data(beat_data),
    .beat_be(beat_be), .par_gen(par_gen), .par_err(par_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one bus clock (called just after a falling edge); returns at the
  // next falling edge, when that clock's registered results are visible.
  task automatic drive(input logic s, input logic a, input logic [63:0] d,
                       input logic [7:0] c, input logic bad);
    start = s; active = a; ad = d; cbe_n = c; par = exp_par ^ bad;
    @(negedge clk);
    exp_par = ^{d[31:0], c[3:0]};
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 addr_valid", addr_valid, 0);
    chk("R1 beat_valid", beat_valid, 0);
    chk("R1 par_err", par_err, 0);
    chk("R1 addr", addr, 0);
    chk("R1 beat_be", beat_be, 0);
    chk("R1 cmd/dac/par_gen", {cmd, dac, par_gen}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_single;
    drive(1, 1, 64'h1122_3344_5566_7788, 8'hA6, 0);
    chk("R2 addr_valid", addr_valid, 1);
    chk("R2 addr", addr, 64'h1122_3344_5566_7788);
    chk("R2 cmd", cmd, 4'h6);
    chk("R2 dac", dac, 0);
    chk("R6 no beat on address clock", beat_valid, 0);
    chk("R7 par_gen", par_gen, ^{32'h5566_7788, 4'h6});
    drive(0, 1, 64'hDEAD_BEEF_0BAD_F00D, 8'hF0, 0);
    chk("R2 single pulse", addr_valid, 0);
    chk("R6 beat_valid", beat_valid, 1);
    chk("R6 beat_data", beat_data, 64'hDEAD_BEEF_0BAD_F00D);
    chk("R5 beat_be", beat_be, 8'h0F);
    chk("R8 no error on good parity", par_err, 0);
    drive(0, 0, 64'h0, 8'hFF, 0);
    chk("R9 no beat when idle", beat_valid, 0);
    chk("R8 still no error", par_err, 0);
  endtask

  task automatic t_dac;
    drive(1, 1, 64'hFFFF_0000_CAFE_1234, 8'h7D, 0);
    chk("R3 no addr_valid after first clock", addr_valid, 0);
    chk("R3 no beat", beat_valid, 0);
    drive(0, 1, 64'h5555_AAAA_0000_00AB, 8'hF3, 0);
    chk("R4 addr_valid", addr_valid, 1);
    chk("R4 dac", dac, 1);
    chk("R4 addr join", addr, 64'h0000_00AB_CAFE_1234);
    chk("R3 cmd from upper lines", cmd, 4'h7);
    chk("R4 second clock is not a beat", beat_valid, 0);
    drive(0, 1, 64'h0102_0304_0506_0708, 8'h7E, 0);
    chk("R4 single pulse", addr_valid, 0);
    chk("R6 dac beat", beat_valid, 1);
    chk("R6 dac beat data", beat_data, 64'h0102_0304_0506_0708);
    chk("R5 lanes 0 and 7", beat_be, 8'h81);
    drive(0, 0, 64'h0, 8'hFF, 0);
  endtask

  task automatic t_burst;
    drive(1, 1, 64'h0000_0000_0000_4000, 8'hF7, 0);
    chk("R2 write addr", addr, 64'h4000);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] c;
      c = 8'h01 << i;
      drive(0, 1, 64'h1000 + 64'(i), ~c, 0);
      chk("R6 burst beat", beat_valid, 1);
      chk("R6 burst data", beat_data, 64'h1000 + 64'(i));
      chk("R5 burst lane", beat_be, c);
    end
    drive(0, 0, 64'h0, 8'hFF, 0);
    chk("R9 burst ends", beat_valid, 0);
  endtask

  task automatic t_parity;
    drive(1, 1, 64'h0000_0000_8000_0000, 8'hF2, 0);
    drive(0, 1, 64'h0000_0000_0000_0001, 8'h00, 0);
    chk("R8 clean", par_err, 0);
    drive(0, 1, 64'h0000_0000_0000_0003, 8'h00, 1);
    chk("R8 mismatch pulse", par_err, 1);
    drive(0, 1, 64'h0000_0000_0000_0007, 8'h00, 0);
    chk("R8 pulse one cycle", par_err, 0);
    chk("R7 par_gen odd", par_gen, 1);
    drive(0, 0, 64'h0, 8'hFF, 0);
    drive(0, 0, 64'h0, 8'hFF, 1);
    chk("R8 unarmed after idle clock", par_err, 0);
  endtask

  task automatic t_restart;
    logic [63:0] keep;
    keep = addr;
    drive(0, 0, 64'h9999_9999_9999_9999, 8'h00, 0);
    chk("R9 idle addr_valid", addr_valid, 0);
    chk("R9 addr held", addr, keep);
    chk("R9 dac held", dac, 0);
    drive(1, 1, 64'h0000_0000_0000_2000, 8'hFC, 0);
    drive(0, 1, 64'h77, 8'h00, 0);
    drive(1, 1, 64'h0000_0000_0000_3000, 8'hFA, 0);
    chk("R9 fresh address after back-to-back start", addr_valid, 1);
    chk("R9 fresh addr", addr, 64'h3000);
    chk("R9 fresh cmd", cmd, 4'hA);
    chk("R9 start clock not a beat", beat_valid, 0);
    drive(0, 0, 64'h0, 8'hFF, 0);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    @(negedge clk);
    t_single();
    t_dac();
    t_burst();
    t_parity();
    t_restart();
    finish_run();
  end
endmodule